// File: doc/BRIEF.md
# Display Active Window Scan Gate

This block walks a raster of source columns and gate rows, one position per pixel tick. It marks every position that lies inside a window set in software-style registers. The window is described by four fields. Horizontal size and horizontal start are counted in units of eight columns, so the window edges on the column axis always fall on eight-column boundaries. Vertical size and vertical start are full 10-bit row counts.

A load strobe captures all four fields at once. Each field is first clamped into its legal range, and an error flag records whether any clamping was needed. The captured values are held as a pending setting. They become the active window only at the end of the frame, when both counters wrap. A frame is therefore never scanned with a mix of old and new edges.

The block also reports the first and last active column and row indices of the active window. It emits one-cycle pulses when a line ends and when a frame ends.

Top module: `scan_window_gate`

## Requirements
- R1: After reset, the column and row counters are 0 and `cfgErr` is 0. The active window is 100 units by 600 rows, starting at 0/0, so the reported indices are columns 0..799 and rows 0..599.
- R2: On each cycle with `tick` high, the column counter advances by one. From `COL_TOTAL-1` it returns to 0. `lineEnd` is high in exactly that wrapping cycle.
- R3: The row counter advances only on a line wrap and returns to 0 from `ROW_TOTAL-1`. `frameEnd` is high in the cycle where both counters wrap.
- R4: `firstRow` equals the active vertical start. `lastRow` equals vertical start plus vertical size minus 1.
- R5: `firstCol` equals horizontal start times 8. `lastCol` equals horizontal start times 8 plus horizontal size times 8 minus 1.
- R6: `inWindow` is high exactly when the current column lies in `firstCol..lastCol` and the current row lies in `firstRow..lastRow`, both bounds inclusive.
- R7: A load clamps each field into its legal range. The ranges are: horizontal size 1..100, vertical size 1..600, horizontal start 0..99, vertical start 0..599. From the cycle after the load, `cfgErr` is 1 if any field was clamped and 0 if all fields were legal.
- R8: A loaded setting has no effect on the reported indices or on `inWindow` until the frame wrap. From the cycle after the wrap, the new setting is in force.
- R9: While `tick` is low, both counters hold their values and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Pixel step enable |
| loadEn | input | 1 | Capture the four setting fields |
| hSizeIn | input | 7 | Horizontal size, units of 8 columns |
| vSizeIn | input | 10 | Vertical size in rows |
| hStartIn | input | 7 | Horizontal start, units of 8 columns |
| vStartIn | input | 10 | Vertical start row |
| colIdx | output | 10 | Current column |
| rowIdx | output | 10 | Current row |
| inWindow | output | 1 | Current position is inside the active window |
| lineEnd | output | 1 | Column counter wraps this cycle |
| frameEnd | output | 1 | Both counters wrap this cycle |
| firstCol | output | 11 | First active column |
| lastCol | output | 11 | Last active column |
| firstRow | output | 11 | First active row |
| lastRow | output | 11 | Last active row |
| cfgErr | output | 1 | Last load needed clamping |

## Verification
The hard case to reach from the ports is the handover at the frame wrap. The bench must hold a new setting pending across a whole frame and then show that it takes effect in the very cycle after the wrap, not earlier and not later. To make this affordable, the bench shrinks the raster to 40 by 30 through the parameters. It then runs every loaded setting through a full frame, while a model that tracks position compares the counters, both pulses and `inWindow` on every cycle. Windows that cover the whole raster, miss it entirely, sit in its middle, or touch its right edge all pass across that wrap.

// File: rtl/scan_window_pkg.sv
package scan_window_pkg;

  localparam int HUNIT_W = 7;
  localparam int VFULL_W = 10;

  localparam int H_SIZE_MAX  = 100;
  localparam int V_SIZE_MAX  = 600;
  localparam int H_START_MAX = 99;
  localparam int V_START_MAX = 599;

  typedef struct packed {
    logic [HUNIT_W-1:0] hSize;
    logic [VFULL_W-1:0] vSize;
    logic [HUNIT_W-1:0] hStart;
    logic [VFULL_W-1:0] vStart;
  } win_cfg_t;

  typedef struct packed {
    logic step;
    logic lineWrap;
    logic frameWrap;
  } scan_strobe_t;

  localparam win_cfg_t CFG_RESET = '{
    hSize:  HUNIT_W'(H_SIZE_MAX),
    vSize:  VFULL_W'(V_SIZE_MAX),
    hStart: '0,
    vStart: '0
  };

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_window_pkg::*;
#(
  parameter int COL_TOTAL = 800,
  parameter int ROW_TOTAL = 600,
  parameter int IDX_W     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  output logic [IDX_W-1:0] colIdx,
  output logic [IDX_W-1:0] rowIdx,
  output scan_strobe_t     strobe
);

  localparam logic [IDX_W-1:0] COL_LAST = IDX_W'(COL_TOTAL - 1);
  localparam logic [IDX_W-1:0] ROW_LAST = IDX_W'(ROW_TOTAL - 1);

  always_comb begin
    strobe.step      = tick;
    strobe.lineWrap  = tick && (colIdx == COL_LAST);
    strobe.frameWrap = strobe.lineWrap && (rowIdx == ROW_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colIdx <= '0;
      rowIdx <= '0;
    end else if (tick) begin
      if (colIdx == COL_LAST) begin
        colIdx <= '0;
        rowIdx <= (rowIdx == ROW_LAST) ? '0 : rowIdx + 1'b1;
      end else begin
        colIdx <= colIdx + 1'b1;
      end
    end
  end

  // R2
  col_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    colIdx <= COL_LAST);

  // R3
  row_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rowIdx <= ROW_LAST);

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineWrap |=> (colIdx == '0));

  // R3
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameWrap |=> (colIdx == '0 && rowIdx == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(colIdx) && $stable(rowIdx)));

endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_window_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OUT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  win_cfg_t         rawCfg,
  input  scan_strobe_t     strobe,
  input  logic [IDX_W-1:0] colIdx,
  input  logic [IDX_W-1:0] rowIdx,
  output logic [OUT_W-1:0] firstCol,
  output logic [OUT_W-1:0] lastCol,
  output logic [OUT_W-1:0] firstRow,
  output logic [OUT_W-1:0] lastRow,
  output logic             inWindow,
  output logic             cfgErr
);

  win_cfg_t fixCfg;
  win_cfg_t pendCfg;
  win_cfg_t actCfg;
  logic     badField;

  always_comb begin
    fixCfg   = rawCfg;
    badField = 1'b0;
    if (rawCfg.hSize == '0) begin
      fixCfg.hSize = HUNIT_W'(1);
      badField     = 1'b1;
    end else if (rawCfg.hSize > HUNIT_W'(H_SIZE_MAX)) begin
      fixCfg.hSize = HUNIT_W'(H_SIZE_MAX);
      badField     = 1'b1;
    end
    if (rawCfg.vSize == '0) begin
      fixCfg.vSize = VFULL_W'(1);
      badField     = 1'b1;
    end else if (rawCfg.vSize > VFULL_W'(V_SIZE_MAX)) begin
      fixCfg.vSize = VFULL_W'(V_SIZE_MAX);
      badField     = 1'b1;
    end
    if (rawCfg.hStart > HUNIT_W'(H_START_MAX)) begin
      fixCfg.hStart = HUNIT_W'(H_START_MAX);
      badField      = 1'b1;
    end
    if (rawCfg.vStart > VFULL_W'(V_START_MAX)) begin
      fixCfg.vStart = VFULL_W'(V_START_MAX);
      badField      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCfg <= CFG_RESET;
      cfgErr  <= 1'b0;
    end else if (loadEn) begin
      pendCfg <= fixCfg;
      cfgErr  <= badField;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg <= CFG_RESET;
    end else if (strobe.frameWrap) begin
      actCfg <= pendCfg;
    end
  end

  always_comb begin
    firstCol = OUT_W'({actCfg.hStart, 3'b000});
    lastCol  = firstCol + OUT_W'({actCfg.hSize, 3'b000}) - 1'b1;
    firstRow = OUT_W'(actCfg.vStart);
    lastRow  = firstRow + OUT_W'(actCfg.vSize) - 1'b1;
    inWindow = (OUT_W'(colIdx) >= firstCol) && (OUT_W'(colIdx) <= lastCol) &&
               (OUT_W'(rowIdx) >= firstRow) && (OUT_W'(rowIdx) <= lastRow);
  end

  // R8
  hold_until_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameWrap |=> $stable(actCfg));

  // R7
  pend_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendCfg.hSize != '0 && pendCfg.hSize <= HUNIT_W'(H_SIZE_MAX) &&
    pendCfg.vSize != '0 && pendCfg.vSize <= VFULL_W'(V_SIZE_MAX) &&
    pendCfg.hStart <= HUNIT_W'(H_START_MAX) &&
    pendCfg.vStart <= VFULL_W'(V_START_MAX));

  // R7
  err_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && rawCfg.vSize > VFULL_W'(V_SIZE_MAX)) |=> cfgErr);

  // R5
  col_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastCol >= firstCol + OUT_W'(7));

  // R4
  row_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastRow >= firstRow);

endmodule

// File: rtl/scan_window_gate.sv
module scan_window_gate
  import scan_window_pkg::*;
#(
  parameter int COL_TOTAL = 800,
  parameter int ROW_TOTAL = 600,
  parameter int IDX_W     = 10,
  parameter int OUT_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             loadEn,
  input  logic [6:0]       hSizeIn,
  input  logic [9:0]       vSizeIn,
  input  logic [6:0]       hStartIn,
  input  logic [9:0]       vStartIn,
  output logic [IDX_W-1:0] colIdx,
  output logic [IDX_W-1:0] rowIdx,
  output logic             inWindow,
  output logic             lineEnd,
  output logic             frameEnd,
  output logic [OUT_W-1:0] firstCol,
  output logic [OUT_W-1:0] lastCol,
  output logic [OUT_W-1:0] firstRow,
  output logic [OUT_W-1:0] lastRow,
  output logic             cfgErr
);

  scan_strobe_t strobe;
  win_cfg_t     rawCfg;

  assign rawCfg = '{hSize: hSizeIn, vSize: vSizeIn, hStart: hStartIn, vStart: vStartIn};

  scan_ctrl #(.COL_TOTAL(COL_TOTAL), .ROW_TOTAL(ROW_TOTAL), .IDX_W(IDX_W)) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .colIdx(colIdx), .rowIdx(rowIdx), .strobe(strobe)
  );

  scan_dp #(.IDX_W(IDX_W), .OUT_W(OUT_W)) dp (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .rawCfg(rawCfg), .strobe(strobe),
    .colIdx(colIdx), .rowIdx(rowIdx),
    .firstCol(firstCol), .lastCol(lastCol), .firstRow(firstRow), .lastRow(lastRow),
    .inWindow(inWindow), .cfgErr(cfgErr)
  );

  assign lineEnd  = strobe.lineWrap;
  assign frameEnd = strobe.frameWrap;

  // R3
  frame_in_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> lineEnd);

endmodule

// File: tb/scan_window_gate_test.sv
`timescale 1ns/1ps
module scan_window_gate_test;

  localparam int COLS = 40;
  localparam int ROWS = 30;

  typedef struct packed {
    logic [6:0]  hs;
    logic [9:0]  vs;
    logic [6:0]  hst;
    logic [9:0]  vst;
    logic [10:0] fc;
    logic [10:0] lc;
    logic [10:0] fr;
    logic [10:0] lr;
    logic        err;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{7'd16,  10'd272,  7'd0,   10'd0,    11'd0,   11'd127,  11'd0,   11'd271,  1'b0},
    '{7'd16,  10'd240,  7'd4,   10'd32,   11'd32,  11'd159,  11'd32,  11'd271,  1'b0},
    '{7'd0,   10'd0,    7'd0,   10'd0,    11'd0,   11'd7,    11'd0,   11'd0,    1'b1},
    '{7'd127, 10'd1023, 7'd127, 10'd1023, 11'd792, 11'd1591, 11'd599, 11'd1198, 1'b1},
    '{7'd100, 10'd600,  7'd99,  10'd599,  11'd792, 11'd1591, 11'd599, 11'd1198, 1'b0},
    '{7'd101, 10'd1,    7'd0,   10'd0,    11'd0,   11'd799,  11'd0,   11'd0,    1'b1},
    '{7'd2,   10'd20,   7'd3,   10'd4,    11'd24,  11'd39,   11'd4,   11'd23,   1'b0},
    '{7'd1,   10'd10,   7'd1,   10'd5,    11'd8,   11'd15,   11'd5,   11'd14,   1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic loadEn = 1'b0;
  logic [6:0] hSizeIn = '0;
  logic [9:0] vSizeIn = '0;
  logic [6:0] hStartIn = '0;
  logic [9:0] vStartIn = '0;
  logic [9:0] colIdx, rowIdx;
  logic inWindow, lineEnd, frameEnd, cfgErr;
  logic [10:0] firstCol, lastCol, firstRow, lastRow;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  int colM = 0, rowM = 0;
  int curFc = 0, curLc = 799, curFr = 0, curLr = 599;
  int penFc = 0, penLc = 799, penFr = 0, penLr = 599;

  always #2 clk = ~clk;

  scan_window_gate #(.COL_TOTAL(COLS), .ROW_TOTAL(ROWS)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .loadEn(loadEn),
    .hSizeIn(hSizeIn), .vSizeIn(vSizeIn), .hStartIn(hStartIn), .vStartIn(vStartIn),
    .colIdx(colIdx), .rowIdx(rowIdx), .inWindow(inWindow),
    .lineEnd(lineEnd), .frameEnd(frameEnd),
    .firstCol(firstCol), .lastCol(lastCol), .firstRow(firstRow), .lastRow(lastRow),
    .cfgErr(cfgErr)
  );

  task automatic checkIdx(input string tag);
    applied++;
    if (int'(firstCol) != curFc || int'(lastCol) != curLc ||
        int'(firstRow) != curFr || int'(lastRow) != curLr) begin
      miscompares++;
      $display("FAIL %s: indices got %0d..%0d / %0d..%0d expected %0d..%0d / %0d..%0d",
               tag, firstCol, lastCol, firstRow, lastRow, curFc, curLc, curFr, curLr);
    end
  endtask

  // One cycle: drive tick at the falling edge, compare before the rising edge.
  task automatic step(input logic doTick, output bit wasFrame);
    bit expLine, expFrame, expIn;
    tick = doTick;
    #1;
    expLine  = doTick && colM == COLS - 1;
    expFrame = expLine && rowM == ROWS - 1;
    expIn    = colM >= curFc && colM <= curLc && rowM >= curFr && rowM <= curLr;
    applied++;
    if (int'(colIdx) != colM || int'(rowIdx) != rowM || lineEnd != expLine ||
        frameEnd != expFrame || inWindow != expIn) begin
      miscompares++;
      $display("FAIL R2 R3 R6 R9: pos %0d,%0d le %0b fe %0b in %0b expected pos %0d,%0d le %0b fe %0b in %0b",
               colIdx, rowIdx, lineEnd, frameEnd, inWindow,
               colM, rowM, expLine, expFrame, expIn);
    end
    wasFrame = expFrame;
    @(negedge clk);
    if (doTick) begin
      if (colM == COLS - 1) begin
        colM = 0;
        rowM = (rowM == ROWS - 1) ? 0 : rowM + 1;
      end else colM++;
    end
    if (expFrame) begin
      curFc = penFc; curLc = penLc; curFr = penFr; curLr = penLr;
    end
  endtask

  task automatic runFrame();
    bit wf;
    wf = 1'b0;
    while (!wf) step(1'b1, wf);
    tick = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    bit wf;
    repeat (3) @(negedge clk);
    // R1: reset state
    applied++;
    if (colIdx != 0 || rowIdx != 0 || cfgErr != 1'b0) begin
      miscompares++;
      $display("FAIL R1: pos %0d,%0d err %0b expected 0,0 err 0", colIdx, rowIdx, cfgErr);
    end
    checkIdx("R1");
    rstN = 1'b1;
    @(negedge clk);

    // R9: counters hold with tick low
    repeat (3) step(1'b0, wf);
    repeat (5) step(1'b1, wf);
    repeat (3) step(1'b0, wf);

    for (int i = 0; i < 8; i++) begin
      tick     = 1'b0;
      loadEn   = 1'b1;
      hSizeIn  = VECS[i].hs;
      vSizeIn  = VECS[i].vs;
      hStartIn = VECS[i].hst;
      vStartIn = VECS[i].vst;
      @(negedge clk);
      loadEn = 1'b0;
      penFc = int'(VECS[i].fc); penLc = int'(VECS[i].lc);
      penFr = int'(VECS[i].fr); penLr = int'(VECS[i].lr);
      // R7: clamp flag after the load
      applied++;
      if (cfgErr != VECS[i].err) begin
        miscompares++;
        $display("FAIL R7: vector %0d cfgErr got %0b expected %0b", i, cfgErr, VECS[i].err);
      end
      // R8: old window still in force before the wrap
      checkIdx("R8");
      runFrame();
      // R4 R5: new window after the wrap
      checkIdx("R4 R5");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule